// File: doc/BRIEF.md
# Destination Address Acceptance Filter

This block sits on the receive side of an Ethernet MAC and decides, for each incoming frame, whether its destination address is wanted. The six destination bytes arrive one per accepted strobe, with a marker on the first. While they stream past, the block advances a byte-wide CRC-32 over them. In parallel it compares them against a programmed station address and tracks whether every byte so far is all ones.

One cycle after the sixth byte, the block pulses a decision. A group (multicast) address is accepted when the bit of a 64-bit hash table selected by the top six CRC bits is set. An individual address is accepted only on an exact station match. The broadcast address is always taken, and a promiscuous control input forces acceptance of everything.

The hash table and station address are loaded through a single 32-bit register write port with a 2-bit register select.

Top module: `mac_addr_filter`

## Requirements
- R1: After reset no decision is pending, and the hash table and station address are all zeros. A group address is therefore rejected until the table is written.
- R2: `dec_vld` is high for exactly one cycle: the cycle after the clock edge that takes the sixth address byte. Bytes that arrive with `byte_vld` but without `byte_first` after the sixth byte, or before any first byte, produce no decision.
- R3: `dec_hash` equals bits 31:26 of a CRC-32 with no final inversion. The CRC starts from all ones, uses the reflected polynomial 0xEDB88320, and takes the six bytes in arrival order, each least-significant bit first.
- R4: A hash index of 32 or more selects bit (index-32) of the high table register. A smaller index selects bit index of the low table register.
- R5: The hash table is consulted only when bit 0 of the first byte is 1. An individual address that does not match the station address is rejected even when the whole table is ones.
- R6: A table of all ones accepts every group address. A table of all zeros rejects every group address that is not broadcast.
- R7: An address equal to the station address is accepted. Station bytes 0..3 are held in bits 31:24, 23:16, 15:8 and 7:0 of the station-low register. Bytes 4 and 5 are held in bits 31:24 and 23:16 of the station-high register.
- R8: The address FF:FF:FF:FF:FF:FF is always accepted, whatever the table holds.
- R9: While `prom_en` is high, every decision is an accept.
- R10: `byte_first` with `byte_vld` always starts a new address, abandoning any partial one. Idle cycles between bytes are allowed.
- R11: A write with `cfg_we` high stores `cfg_wdata` in the register chosen by `cfg_sel`: 0 = hash low, 1 = hash high, 2 = station low, 3 = station high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Address byte present on `byte_data` |
| byte_first | input | 1 | Marks the first byte of a destination address |
| byte_data | input | 8 | Address byte |
| prom_en | input | 1 | Promiscuous mode: accept every address |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (see R11) |
| cfg_wdata | input | 32 | Register write data |
| dec_vld | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Accept (1) or reject (0), valid with `dec_vld` |
| dec_hash | output | 6 | Hash index of the address, valid with `dec_vld` |

## Verification
Group addresses are swept over sixteen values of the last byte. Each sweep sets only the table bit predicted by a bench-side CRC, so the run covers both the high and the low table register and catches bit-order or polynomial slips. The same sweep with the table inverted shows that no neighbouring bit is consulted. Individual addresses are sent with a matching station address, with one mismatching byte, and with an all-ones table, which separates exact matching from hashing. Broadcast, promiscuous mode, a restart in mid-address, idle gaps and surplus bytes show that accept sources and pulse timing stay distinct.

// File: rtl/mac_addr_filter.sv
module mac_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter logic [31:0] CRC_POLY = 32'hEDB88320
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        byte_vld,
  input  logic        byte_first,
  input  logic [7:0]  byte_data,
  input  logic        prom_en,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic        dec_vld,
  output logic        dec_accept,
  output logic [5:0]  dec_hash
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES - 1);

  logic [31:0] hash_lo_q, hash_hi_q, sta_lo_q;
  logic [15:0] sta_hi_q;
  logic [31:0] crc_q;
  logic [CW-1:0] cnt_q;
  logic grp_q, sta_ok_q, bc_q, done_q;

  function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++)
      r = (r >> 1) ^ ((r[0] ^ d[b]) ? CRC_POLY : 32'h0);
    return r;
  endfunction

  wire [47:0] sta_all = {sta_lo_q, sta_hi_q};
  wire        busy    = (cnt_q != '0) && (cnt_q <= LAST);
  wire [CW-1:0] pos   = byte_first ? '0 : cnt_q;
  wire [7:0]  sta_b   = sta_all[47 - 8*pos -: 8];
  wire        take    = byte_vld && (byte_first || busy);
  wire [31:0] crc_in  = byte_first ? 32'hFFFF_FFFF : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hash_lo_q <= '0;
      hash_hi_q <= '0;
      sta_lo_q  <= '0;
      sta_hi_q  <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: hash_lo_q <= cfg_wdata;
        2'd1: hash_hi_q <= cfg_wdata;
        2'd2: sta_lo_q  <= cfg_wdata;
        default: sta_hi_q <= cfg_wdata[31:16];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= '1;
      cnt_q    <= '0;
      grp_q    <= 1'b0;
      sta_ok_q <= 1'b0;
      bc_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= take && !byte_first && (cnt_q == LAST);
      if (take) begin
        crc_q    <= crc_byte(crc_in, byte_data);
        cnt_q    <= pos + 1'b1;
        sta_ok_q <= (byte_first || sta_ok_q) && (byte_data == sta_b);
        bc_q     <= (byte_first || bc_q) && (byte_data == 8'hFF);
        if (byte_first) grp_q <= byte_data[0];
      end
    end
  end

  wire hash_bit = dec_hash[5] ? hash_hi_q[dec_hash[4:0]] : hash_lo_q[dec_hash[4:0]];

  assign dec_vld    = done_q;
  assign dec_hash   = crc_q[31:26];
  assign dec_accept = prom_en || bc_q || sta_ok_q || (grp_q && hash_bit);
endmodule

// File: rtl/mac_addr_filter_chk.sv
module mac_addr_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic byte_vld,
  input logic prom_en,
  input logic dec_vld,
  input logic dec_accept,
  input logic grp_q,
  input logic sta_ok_q,
  input logic bc_q
);
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |=> !dec_vld);
  a_r2_follows_byte: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld |-> $past(byte_vld));
  a_r9_promisc: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && prom_en) |-> dec_accept);
  a_r8_broadcast: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && bc_q) |-> dec_accept);
  a_r7_station: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && sta_ok_q) |-> dec_accept);
  a_r5_unicast_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_vld && !grp_q && !sta_ok_q && !prom_en) |-> !dec_accept);
endmodule

bind mac_addr_filter mac_addr_filter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .prom_en(prom_en),
  .dec_vld(dec_vld), .dec_accept(dec_accept), .grp_q(grp_q),
  .sta_ok_q(sta_ok_q), .bc_q(bc_q)
);

// File: tb/mac_addr_filter_tb.sv
module mac_addr_filter_tb_top;
  logic clk = 0, rst_n = 0;
  logic byte_vld = 0, byte_first = 0, prom_en = 0, cfg_we = 0;
  logic [7:0] byte_data = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic dec_vld, dec_accept;
  logic [5:0] dec_hash;
  int checks = 0, errors = 0;
  bit seen_hi = 0, seen_lo = 0;

  always #4 clk = ~clk;

  mac_addr_filter dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ref_hash(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      logic [7:0] d = a[47-8*i -: 8];
      for (int b = 0; b < 8; b++)
        c = (c >> 1) ^ ((c[0] ^ d[b]) ? 32'hEDB88320 : 32'h0);
    end
    return c[31:26];
  endfunction

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input logic [47:0] a, input bit gaps, output logic acc, output logic [5:0] h);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      byte_vld = 1; byte_first = (i == 0); byte_data = a[47-8*i -: 8];
      if (gaps && i < 5) begin @(negedge clk); byte_vld = 0; chk("R2 no early pulse", dec_vld, 0); end
    end
    @(negedge clk); byte_vld = 0; byte_first = 0;
    chk("R2 pulse after sixth byte", dec_vld, 1);
    acc = dec_accept; h = dec_hash;
    @(negedge clk);
    chk("R2 pulse one cycle", dec_vld, 0);
  endtask

  task automatic t_reset;
    logic a; logic [5:0] h;
    chk("R1 no decision in reset", dec_vld, 0);
    @(negedge clk); rst_n = 1;
    send(48'h01005E000001, 0, a, h);
    chk("R1 cleared table rejects group", a, 0);
  endtask

  task automatic t_station;
    logic a; logic [5:0] h;
    wr(2, 32'h02112233); wr(3, 32'h4455ABCD);
    send(48'h021122334455, 0, a, h); chk("R7 R11 station match", a, 1);
    send(48'h021122334456, 0, a, h); chk("R7 last byte mismatch", a, 0);
    send(48'h121122334455, 0, a, h); chk("R7 first byte mismatch", a, 0);
    send(48'h021122334455, 1, a, h); chk("R10 idle gaps", a, 1);
  endtask

  task automatic t_unicast_ignores_hash;
    logic a; logic [5:0] h;
    wr(0, '1); wr(1, '1);
    send(48'h00AABBCCDDEE, 0, a, h); chk("R5 unicast ignores table", a, 0);
    send(48'h01AABBCCDDEE, 0, a, h); chk("R6 all-ones table accepts group", a, 1);
    wr(0, 0); wr(1, 0);
    send(48'h01AABBCCDDEE, 0, a, h); chk("R6 zero table rejects group", a, 0);
  endtask

  task automatic t_hash_sweep;
    logic a; logic [5:0] h, e;
    for (int k = 0; k < 16; k++) begin
      logic [47:0] ad = {40'h01005E7F00, 8'(k * 17)};
      e = ref_hash(ad);
      if (e[5]) seen_hi = 1; else seen_lo = 1;
      wr(0, e[5] ? 32'h0 : (32'h1 << e[4:0]));
      wr(1, e[5] ? (32'h1 << e[4:0]) : 32'h0);
      send(ad, 0, a, h);
      chk("R3 hash index", {26'h0, h}, {26'h0, e});
      chk("R4 selected table bit accepts", a, 1);
      wr(0, e[5] ? 32'hFFFF_FFFF : ~(32'h1 << e[4:0]));
      wr(1, e[5] ? ~(32'h1 << e[4:0]) : 32'hFFFF_FFFF);
      send(ad, 0, a, h);
      chk("R4 other bits ignored", a, 0);
    end
    chk("R4 both halves covered", {seen_hi, seen_lo}, 2'b11);
    wr(0, 0); wr(1, 0);
  endtask

  task automatic t_bcast_prom;
    logic a; logic [5:0] h;
    send(48'hFFFFFFFFFFFF, 0, a, h); chk("R8 broadcast", a, 1);
    send(48'hFFFFFFFFFFFE, 0, a, h); chk("R8 near-broadcast", a, 0);
    prom_en = 1;
    send(48'h00DEADBEEF00, 0, a, h); chk("R9 promiscuous", a, 1);
    prom_en = 0;
    send(48'h00DEADBEEF00, 0, a, h); chk("R9 promiscuous off", a, 0);
  endtask

  task automatic t_restart_extra;
    logic a; logic [5:0] h;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); byte_vld = 1; byte_first = (i == 0); byte_data = 8'h00;
    end
    send(48'h021122334455, 0, a, h); chk("R10 restart on first", a, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); byte_vld = 1; byte_first = 0; byte_data = 8'h55;
      chk("R2 surplus bytes no pulse", dec_vld, 0);
    end
    @(negedge clk); byte_vld = 0;
    chk("R2 surplus bytes no pulse", dec_vld, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        t_station();
        t_unicast_ignores_hash();
        t_hash_sweep();
        t_bcast_prom();
        t_restart_extra();
      end
      begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule